// File: doc/BRIEF.md
# Erased Sector Zero-Bit Screen

This block inspects one flash sector as it streams past, byte by byte: a data region followed by the stored check bytes. It counts the bits that read as zero, keeping a separate tally for the data region and for the check-byte region. When the error decoder has already declared the sector uncorrectable, these counts let the host tell a freshly erased sector from a damaged one. An erased sector reads as all ones, so it shows few or no zero bits. Its stored check bytes, however, do not match what the decoder expects for all-ones data.

A sector begins with a `start` pulse, which clears both tallies. Bytes are then offered with `in_valid`, and the first and last bytes of the sector are flagged. One cycle after the final check byte is taken, `done` rises. At that point the block presents the data zero count, the combined count, a three-way verdict and a flag. The flag asks the surrounding logic to overwrite the data region with 0xFF. Each tally stops growing once it exceeds the threshold, so it stays small however many zeros a sector holds.

Top module: `edz_detector`

## Requirements
- R1: While reset is held and after it is released, `done` is low, `fill_ff` is low, both counts read 0 and `verdict` reads 2'b00.
- R2: A `start` pulse clears both tallies and drops `done` at the next clock edge. A byte offered in the same cycle as `start` is not counted.
- R3: Each byte taken adds the number of zero bits it holds to one tally. The first DATA_BYTES bytes (512) go to the data tally and the next ECC_BYTES bytes (13) go to the check tally. `data_zeros` shows the data tally, and `total_zeros` shows the sum of the two tallies.
- R4: Once a tally holds a value above THRESH (8), later bytes in that region leave it unchanged. A tally therefore never exceeds THRESH+8. A data region of all 0x00 reads 16.
- R5: When `total_zeros` ≤ 8 and `data_zeros` = 0, `verdict` is 2'b00 (clean erase) and `fill_ff` is low. Zero bits in the check bytes alone do not change this verdict.
- R6: When `total_zeros` ≤ 8 and `data_zeros` > 0, `verdict` is 2'b01 (erased with flipped bits). While `done` is high, `fill_ff` is high, and `data_zeros` gives the number of bits corrected.
- R7: When `total_zeros` > 8, `verdict` is 2'b10 (uncorrectable) and `fill_ff` is low.
- R8: `done` rises one cycle after the byte flagged `in_last` is taken. From then until the next `start`, `done` and all outputs hold, and bytes offered during that time are ignored.
- R9: A cycle with `in_valid` low does not advance the byte position and does not change either tally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a new sector; clears the tallies |
| in_valid | input | 1 | Byte on `in_byte` is offered this cycle |
| in_byte | input | 8 | Sector byte (data region first, then check bytes) |
| in_first | input | 1 | Marks the first byte of the sector |
| in_last | input | 1 | Marks the final check byte |
| done | output | 1 | Result valid; held until the next `start` |
| data_zeros | output | CNT_W (5) | Saturating zero count of the data region |
| total_zeros | output | CNT_W+1 (6) | Data tally plus check tally |
| verdict | output | 2 | 00 clean erase, 01 erased with flips, 10 uncorrectable |
| fill_ff | output | 1 | Data region must be replaced by 0xFF |

## Verification
The checks take for granted a well-formed stream: exactly DATA_BYTES+ECC_BYTES bytes between a `start` pulse and the byte flagged `in_last`, with `in_first` on position zero and `in_last` on the final position. The marker assertions fire if that framing is broken. The stimulus generator always emits full sectors with the markers placed on those positions, and it inserts idle cycles only with `in_valid` low. The only bytes sent outside a sector are sent deliberately after `done`, where the requirements say they must be ignored.

// File: rtl/edz_pkg.sv
package edz_pkg;

  typedef enum logic [1:0] {
    VERD_CLEAN  = 2'b00,
    VERD_FLIPS  = 2'b01,
    VERD_UNCORR = 2'b10
  } verdict_e;

  // number of bits that read as zero in one byte
  function automatic logic [3:0] zeros_in_byte(input logic [7:0] b);
    logic [3:0] n;
    n = 4'd0;
    for (int k = 0; k < 8; k++) begin
      n = n + {3'b000, ~b[k]};
    end
    return n;
  endfunction

endpackage

// File: rtl/edz_sequencer.sv
module edz_sequencer #(
  parameter int DATA_BYTES = 512,
  parameter int ECC_BYTES  = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic in_valid_i,
  input  logic in_first_i,
  input  logic in_last_i,
  output logic take_o,
  output logic is_data_o,
  output logic done_o
);
  localparam int IDX_W = $clog2(DATA_BYTES + ECC_BYTES);
  localparam logic [IDX_W-1:0] DATA_END = IDX_W'(DATA_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BYTES + ECC_BYTES - 1);

  logic [IDX_W-1:0] idx_q;
  logic             busy_q;
  logic             done_q;

  assign take_o    = busy_q && in_valid_i && !start_i;
  assign is_data_o = idx_q < DATA_END;
  assign done_o    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      idx_q  <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (take_o) begin
      idx_q <= idx_q + 1'b1;
      if (in_last_i) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  // input framing assumptions (R8)
  a_r8_first_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && in_first_i) |-> (idx_q == '0));
  a_r8_last_on_final: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && in_last_i) |-> (idx_q == LAST_IDX));
  a_r8_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && in_last_i) |=> done_q);
  a_r2_start_drops_done: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_q && busy_q));

endmodule

// File: rtl/edz_region_tally.sv
module edz_region_tally #(
  parameter int THRESH = 8,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [3:0]       zeros_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESH);
  localparam logic [CNT_W-1:0] CEIL  = CNT_W'(THRESH + 8);

  logic [CNT_W-1:0] cnt_q;
  logic             over_w;

  assign over_w = cnt_q > LIMIT;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (en_i && !over_w)  cnt_q <= cnt_q + CNT_W'(zeros_i);
  end

  a_r4_hold_when_over: assert property (@(posedge clk) disable iff (!rst_n)
    (over_w && !clr_i) |=> $stable(cnt_q));
  a_r4_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CEIL);
  a_r9_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/edz_verdict.sv
module edz_verdict #(
  parameter int THRESH = 8,
  parameter int CNT_W  = 5
) (
  input  logic             done_i,
  input  logic [CNT_W-1:0] data_cnt_i,
  input  logic [CNT_W-1:0] ecc_cnt_i,
  output logic [CNT_W:0]   total_o,
  output logic [1:0]       verdict_o,
  output logic             fill_o
);
  import edz_pkg::*;
  localparam logic [CNT_W:0] LIMIT_T = (CNT_W+1)'(THRESH);

  verdict_e v_w;

  assign total_o = {1'b0, data_cnt_i} + {1'b0, ecc_cnt_i};

  always_comb begin
    if (total_o > LIMIT_T)        v_w = VERD_UNCORR;
    else if (data_cnt_i == '0)    v_w = VERD_CLEAN;
    else                          v_w = VERD_FLIPS;
  end

  assign verdict_o = v_w;
  assign fill_o    = done_i && (v_w == VERD_FLIPS);

endmodule

// File: rtl/edz_detector.sv
module edz_detector #(
  parameter int DATA_BYTES = 512,
  parameter int ECC_BYTES  = 13,
  parameter int THRESH     = 8,
  localparam int CNT_W     = $clog2(THRESH + 9)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_first,
  input  logic             in_last,
  output logic             done,
  output logic [CNT_W-1:0] data_zeros,
  output logic [CNT_W:0]   total_zeros,
  output logic [1:0]       verdict,
  output logic             fill_ff
);
  import edz_pkg::*;
  localparam logic [CNT_W:0] LIMIT_T = (CNT_W+1)'(THRESH);

  logic             take_w;
  logic             is_data_w;
  logic [3:0]       byte_zeros_w;
  logic [CNT_W-1:0] tally_w [2];

  assign byte_zeros_w = zeros_in_byte(in_byte);

  edz_sequencer #(.DATA_BYTES(DATA_BYTES), .ECC_BYTES(ECC_BYTES)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .in_valid_i(in_valid),
    .in_first_i(in_first), .in_last_i(in_last),
    .take_o(take_w), .is_data_o(is_data_w), .done_o(done)
  );

  // region 0 = data bytes, region 1 = stored check bytes
  for (genvar g = 0; g < 2; g++) begin : g_region
    logic en_w;
    assign en_w = take_w && (is_data_w == (g == 0));
    edz_region_tally #(.THRESH(THRESH), .CNT_W(CNT_W)) tally_i (
      .clk(clk), .rst_n(rst_n), .clr_i(start), .en_i(en_w),
      .zeros_i(byte_zeros_w), .cnt_o(tally_w[g])
    );
  end

  edz_verdict #(.THRESH(THRESH), .CNT_W(CNT_W)) verdict_i (
    .done_i(done), .data_cnt_i(tally_w[0]), .ecc_cnt_i(tally_w[1]),
    .total_o(total_zeros), .verdict_o(verdict), .fill_o(fill_ff)
  );

  assign data_zeros = tally_w[0];

  a_r6_fill_needs_flips: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ff |-> (done && data_zeros != '0 && total_zeros <= LIMIT_T));
  a_r8_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(data_zeros) && $stable(total_zeros) && done));
  a_r7_uncorr_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict == 2'b10) |-> !fill_ff);

endmodule

// File: tb/edz_detector_tb.sv
module edz_detector_tb_top;
  localparam int NDATA = 512;
  localparam int NECC  = 13;
  localparam int NTOT  = NDATA + NECC;
  localparam int LIM   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [7:0] in_byte = 8'hFF;
  logic done, fill_ff;
  logic [4:0] data_zeros;
  logic [5:0] total_zeros;
  logic [1:0] verdict;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  edz_detector dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_byte(in_byte), .in_first(in_first), .in_last(in_last),
    .done(done), .data_zeros(data_zeros), .total_zeros(total_zeros),
    .verdict(verdict), .fill_ff(fill_ff)
  );

  // vector: {data zero bits, check zero bits, data all 0x00, idle gaps}
  localparam logic [31:0] VECS [10] = '{
    {8'd0, 8'd0, 8'd0, 8'd0},
    {8'd0, 8'd5, 8'd0, 8'd0},
    {8'd3, 8'd2, 8'd0, 8'd0},
    {8'd8, 8'd0, 8'd0, 8'd0},
    {8'd4, 8'd4, 8'd0, 8'd1},
    {8'd5, 8'd4, 8'd0, 8'd0},
    {8'd9, 8'd0, 8'd0, 8'd0},
    {8'd0, 8'd9, 8'd0, 8'd1},
    {8'd0, 8'd0, 8'd1, 8'd0},
    {8'd1, 8'd0, 8'd0, 8'd1}
  };

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] gen_byte(int d, int e, int az, int i);
    if (i < NDATA) begin
      if (az != 0) return 8'h00;
      if ((i % 3) == 0 && (i / 3) < d) return ~(8'h01 << ((i / 3) % 8));
      return 8'hFF;
    end
    if ((i - NDATA) < e) return ~(8'h80 >> ((i - NDATA) % 8));
    return 8'hFF;
  endfunction

  task automatic send_sector(int d, int e, int az, int gaps);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < NTOT; i++) begin
      if (gaps != 0 && (i % 7) == 3) begin
        in_valid = 1'b0; in_byte = 8'h00; in_first = 1'b0; in_last = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_byte  = gen_byte(d, e, az, i);
      in_first = (i == 0);
      in_last  = (i == NTOT - 1);
      @(negedge clk);
    end
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_byte = 8'hFF;
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int exp_d, exp_e, exp_t, exp_v;
    logic [4:0] held;
    repeat (3) @(negedge clk);
    check("R1 done in reset", int'(done), 0);
    check("R1 data_zeros in reset", int'(data_zeros), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after reset", int'(done), 0);
    check("R1 total after reset", int'(total_zeros), 0);
    check("R1 verdict after reset", int'(verdict), 0);
    check("R1 fill after reset", int'(fill_ff), 0);

    foreach (VECS[v]) begin
      int d, e, az, gp;
      d = int'(VECS[v][31:24]); e = int'(VECS[v][23:16]);
      az = int'(VECS[v][15:8]); gp = int'(VECS[v][7:0]);
      exp_d = 0; exp_e = 0;
      for (int i = 0; i < NTOT; i++) begin
        int z;
        z = $countones(~gen_byte(d, e, az, i));
        if (i < NDATA) begin if (exp_d <= LIM) exp_d += z; end
        else begin if (exp_e <= LIM) exp_e += z; end
      end
      exp_t = exp_d + exp_e;
      exp_v = (exp_t > LIM) ? 2 : ((exp_d == 0) ? 0 : 1);
      send_sector(d, e, az, gp);
      check($sformatf("R8 done vec%0d", v), int'(done), 1);
      check($sformatf("R3/R4 data_zeros vec%0d", v), int'(data_zeros), exp_d);
      check($sformatf("R3 total_zeros vec%0d", v), int'(total_zeros), exp_t);
      check($sformatf("R5/R6/R7 verdict vec%0d", v), int'(verdict), exp_v);
      check($sformatf("R6 fill_ff vec%0d", v), int'(fill_ff), (exp_v == 1) ? 1 : 0);
    end

    // R8: bytes after done are ignored, outputs held (last vector: 1 data flip)
    held = data_zeros;
    for (int i = 0; i < 20; i++) begin
      in_valid = 1'b1; in_byte = 8'h00; in_last = (i == 19);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    check("R8 data_zeros held after done", int'(data_zeros), int'(held));
    check("R8 total held after done", int'(total_zeros), 1);
    check("R8 done held", int'(done), 1);
    check("R6 fill held", int'(fill_ff), 1);

    // R2: start clears and drops done; byte in start cycle not counted
    start = 1'b1; in_valid = 1'b1; in_byte = 8'h00;
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0; in_byte = 8'hFF;
    check("R2 done dropped", int'(done), 0);
    check("R2 data_zeros cleared", int'(data_zeros), 0);
    check("R2 total cleared", int'(total_zeros), 0);

    // R9: idle cycles with zero bytes on the bus change nothing
    in_byte = 8'h00;
    repeat (5) @(negedge clk);
    check("R9 idle leaves tally", int'(data_zeros), 0);

    // R4: saturation holds mid-sector while bytes keep flowing
    for (int i = 0; i < 4; i++) begin
      in_valid = 1'b1; in_byte = 8'h00; in_first = (i == 0);
      @(negedge clk);
    end
    in_valid = 1'b0; in_first = 1'b0;
    check("R4 saturated data tally", int'(data_zeros), 16);
    check("R7 verdict uncorrectable mid-sector", int'(verdict), 2);

    // R1: reset mid-sector
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 data_zeros after mid reset", int'(data_zeros), 0);
    check("R1 done after mid reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule